// File: doc/BRIEF.md
# Regulator Power Sequencing and Fault Controller

This block is the digital supervisor of a step-down switching regulator. It decides when the power switches may run, and it steps the converter through a start delay, a soft-start ramp and a calibration window before normal operation. In normal operation it chooses between fixed-frequency PWM and light-load PFM. It also reacts to sustained current limit and to over-temperature.

It consumes digital flags from the analog front end: input supply above lockout, the enable pin, a software enable bit, an over-temperature flag, per-switching-cycle current-limit and inductor zero-crossing flags, and an in-regulation flag. A strobe `sw_cycle` marks each switching cycle. The per-cycle flags count only on that strobe. It also takes the two mode control bits, a per-setpoint PFM bit and a PFM-exit request. All time windows are parameters counted in controller clock cycles.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: The converter runs only while `supply_ok`, `en_pin` and `sw_en` are all 1. When any of them is 0 at a clock edge, the block returns to off at that edge: `sw_enable` and `ramp_en` go to 0 and the current-limit and zero-crossing counts are cleared.
- R2: After the three enables rise, `ramp_en` stays 0 for exactly `DLY_CYC` clock cycles and then goes to 1.
- R3: While `ramp_en` is 1, `pfm_allow` is 1 and `force_pwm` is 0, whatever the mode bits are. The ramp lasts until `in_reg` is seen at 1.
- R4: When `in_reg` is 1 during the ramp, `force_pwm` is 1 for exactly `CAL_CYC` cycles. Zero-crossing strobes in that window are not counted.
- R5: In normal operation, PFM (`pfm_allow`=1, `force_pwm`=0) is entered on the `ZC_RUN`-th consecutive `sw_cycle` strobe that has `zero_cross` high, provided PFM is permitted. A strobe without a crossing restarts the count.
- R6: The 2-bit `mode_sel` field permits PFM as follows: 2'b00 follows `setpt_pfm` (1 means permitted), 2'b01 and 2'b11 permit it, and 2'b10 forbids it (forced PWM). Losing permission while in PFM returns the block to PWM at the next edge.
- R7: `pfm_exit_req`=1 while in PFM returns the block to PWM at the next edge.
- R8: When a switching cycle has `ilim_cycle` high and is the (`ILIM_RUN`+1)-th consecutive such strobe, the switches turn off for `RETRY_CYC` cycles, then a fresh ramp starts. `ILIM_RUN` consecutive strobes do not trip, and a strobe without the flag clears the count.
- R9: `over_temp`=1 turns the switches off at the next edge and holds them off. After the flag clears, the block restarts with a ramp.
- R10: `discharge_en` is 1 only in the off state and only while `discharge_cfg` is 1.
- R11: `reg_reset` is 1 exactly when `supply_ok` and `en_pin` are not both 1. The software enable does not affect it.
- R12: `force_pwm` and `pfm_allow` are never both 1. After reset, all switching outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Input supply above lockout threshold |
| en_pin | input | 1 | Hardware enable |
| sw_en | input | 1 | Software enable bit |
| over_temp | input | 1 | Die over-temperature flag (hysteresis applied upstream) |
| sw_cycle | input | 1 | One-clock strobe per switching cycle |
| ilim_cycle | input | 1 | Current limit hit in this switching cycle |
| zero_cross | input | 1 | Inductor current crossed zero in this switching cycle |
| in_reg | input | 1 | Output has reached its setpoint |
| mode_sel | input | 2 | Mode control field |
| setpt_pfm | input | 1 | Per-setpoint PFM permission bit |
| pfm_exit_req | input | 1 | Load too heavy for PFM |
| discharge_cfg | input | 1 | Discharge the output when off |
| sw_enable | output | 1 | Power switches may operate |
| ramp_en | output | 1 | Soft-start ramp running |
| force_pwm | output | 1 | Modulator runs fixed-frequency PWM |
| pfm_allow | output | 1 | Modulator runs in PFM |
| discharge_en | output | 1 | Output discharge path on |
| reg_reset | output | 1 | Hold control registers at defaults |

## Verification
The hardest situation to reach is the one where the fault counters must be cleared by a loss of enable. The normal path through the ramp clears the current-limit count anyway whenever a clean strobe arrives, which would hide the bug. The stimulus therefore builds up exactly `ILIM_RUN` limited strobes in normal operation and then drops the software enable. It brings the block back up with no strobes at all, and finally sends a single limited strobe, which must not trip. The PFM permission is swept over all eight combinations of mode field and setpoint bit. The trip threshold is approached from both sides, including a run broken by one clean strobe.

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl #(
  parameter int DLY_CYC   = 100,
  parameter int CAL_CYC   = 10,
  parameter int RETRY_CYC = 80,
  parameter int ILIM_RUN  = 32,
  parameter int ZC_RUN    = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       supply_ok,
  input  logic       en_pin,
  input  logic       sw_en,
  input  logic       over_temp,
  input  logic       sw_cycle,
  input  logic       ilim_cycle,
  input  logic       zero_cross,
  input  logic       in_reg,
  input  logic [1:0] mode_sel,
  input  logic       setpt_pfm,
  input  logic       pfm_exit_req,
  input  logic       discharge_cfg,
  output logic       sw_enable,
  output logic       ramp_en,
  output logic       force_pwm,
  output logic       pfm_allow,
  output logic       discharge_en,
  output logic       reg_reset
);
  localparam int TMAX = (DLY_CYC > CAL_CYC) ? ((DLY_CYC > RETRY_CYC) ? DLY_CYC : RETRY_CYC)
                                             : ((CAL_CYC > RETRY_CYC) ? CAL_CYC : RETRY_CYC);
  localparam int TW = $clog2(TMAX + 1);
  localparam int IW = $clog2(ILIM_RUN + 1);
  localparam int ZW = $clog2(ZC_RUN + 1);
  localparam logic [TW-1:0] T_DLY = TW'(DLY_CYC - 1);
  localparam logic [TW-1:0] T_CAL = TW'(CAL_CYC - 1);
  localparam logic [TW-1:0] T_RET = TW'(RETRY_CYC - 1);
  localparam logic [IW-1:0] I_TOP = IW'(ILIM_RUN);
  localparam logic [ZW-1:0] Z_TOP = ZW'(ZC_RUN - 1);

  typedef enum logic [2:0] {S_OFF, S_WAIT, S_RAMP, S_CAL, S_RUN, S_RETRY, S_HOT} st_t;

  st_t           st;
  logic [TW-1:0] tmr;
  logic [IW-1:0] ilim_cnt;
  logic [ZW-1:0] zc_cnt;
  logic          pfm_on;

  wire go     = supply_ok & en_pin & sw_en;
  wire live   = (st == S_RAMP) | (st == S_CAL) | (st == S_RUN);
  wire trip   = live & sw_cycle & ilim_cycle & (ilim_cnt == I_TOP);
  wire pfm_ok = (mode_sel == 2'b00) ? setpt_pfm : (mode_sel != 2'b10);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_OFF;
      tmr      <= '0;
      ilim_cnt <= '0;
      zc_cnt   <= '0;
      pfm_on   <= 1'b0;
    end else if (!go) begin
      st       <= S_OFF;
      tmr      <= '0;
      ilim_cnt <= '0;
      zc_cnt   <= '0;
      pfm_on   <= 1'b0;
    end else if (st != S_OFF && over_temp) begin
      st       <= S_HOT;
      tmr      <= '0;
      ilim_cnt <= '0;
      zc_cnt   <= '0;
      pfm_on   <= 1'b0;
    end else if (trip) begin
      st       <= S_RETRY;
      tmr      <= '0;
      ilim_cnt <= '0;
      zc_cnt   <= '0;
      pfm_on   <= 1'b0;
    end else begin
      tmr <= tmr + 1'b1;
      if (live && sw_cycle) ilim_cnt <= ilim_cycle ? ilim_cnt + 1'b1 : '0;
      case (st)
        S_OFF:   begin st <= S_WAIT; tmr <= '0; end
        S_WAIT:  if (tmr == T_DLY) begin st <= S_RAMP; tmr <= '0; end
        S_RAMP:  if (in_reg) begin st <= S_CAL; tmr <= '0; end
        S_CAL:   if (tmr == T_CAL) begin st <= S_RUN; tmr <= '0; end
        S_RUN: begin
          tmr <= '0;
          if (pfm_on) begin
            if (pfm_exit_req || !pfm_ok) begin
              pfm_on <= 1'b0;
              zc_cnt <= '0;
            end
          end else if (sw_cycle) begin
            if (zero_cross && pfm_ok) begin
              if (zc_cnt == Z_TOP) begin
                pfm_on <= 1'b1;
                zc_cnt <= '0;
              end else begin
                zc_cnt <= zc_cnt + 1'b1;
              end
            end else begin
              zc_cnt <= '0;
            end
          end
        end
        S_RETRY: if (tmr == T_RET) begin st <= S_RAMP; tmr <= '0; end
        S_HOT:   begin st <= S_RAMP; tmr <= '0; end
        default: st <= S_OFF;
      endcase
    end
  end

  assign sw_enable    = live;
  assign ramp_en      = (st == S_RAMP);
  assign force_pwm    = (st == S_CAL) | ((st == S_RUN) & ~pfm_on);
  assign pfm_allow    = (st == S_RAMP) | ((st == S_RUN) & pfm_on);
  assign discharge_en = (st == S_OFF) & discharge_cfg;
  assign reg_reset    = ~(supply_ok & en_pin);
endmodule

// File: rtl/pwr_seq_chk.sv
module pwr_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic supply_ok,
  input logic en_pin,
  input logic sw_en,
  input logic over_temp,
  input logic sw_cycle,
  input logic ilim_cycle,
  input logic in_reg,
  input logic sw_enable,
  input logic ramp_en,
  input logic force_pwm,
  input logic pfm_allow,
  input logic discharge_en
);
  // R1
  en_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(supply_ok && en_pin && sw_en) |=> (!sw_enable && !ramp_en));
  // R9
  hot_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    over_temp |=> !sw_enable);
  // R12
  mode_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(force_pwm && pfm_allow));
  // R3
  ramp_pfm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ramp_en |-> (pfm_allow && !force_pwm && sw_enable));
  // R10
  discharge_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    discharge_en |-> (!sw_enable && !ramp_en));
  // R4
  cal_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ramp_en && in_reg && supply_ok && en_pin && sw_en && !over_temp && !(sw_cycle && ilim_cycle))
      |=> (force_pwm && !ramp_en));
endmodule

bind pwr_seq_ctrl pwr_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .en_pin(en_pin), .sw_en(sw_en),
  .over_temp(over_temp), .sw_cycle(sw_cycle), .ilim_cycle(ilim_cycle), .in_reg(in_reg),
  .sw_enable(sw_enable), .ramp_en(ramp_en), .force_pwm(force_pwm), .pfm_allow(pfm_allow),
  .discharge_en(discharge_en)
);

// File: tb/tb_pwr_seq_ctrl.sv
`timescale 1ns/1ps
module tb_pwr_seq_ctrl;
  localparam int DLY = 4, CAL = 3, RET = 5, IL = 4, ZC = 4;

  logic clk = 1'b0;
  logic rst_n, supply_ok, en_pin, sw_en, over_temp, sw_cycle, ilim_cycle, zero_cross;
  logic in_reg, setpt_pfm, pfm_exit_req, discharge_cfg;
  logic [1:0] mode_sel;
  logic sw_enable, ramp_en, force_pwm, pfm_allow, discharge_en, reg_reset;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  pwr_seq_ctrl #(.DLY_CYC(DLY), .CAL_CYC(CAL), .RETRY_CYC(RET), .ILIM_RUN(IL), .ZC_RUN(ZC)) dut (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .en_pin(en_pin), .sw_en(sw_en),
    .over_temp(over_temp), .sw_cycle(sw_cycle), .ilim_cycle(ilim_cycle), .zero_cross(zero_cross),
    .in_reg(in_reg), .mode_sel(mode_sel), .setpt_pfm(setpt_pfm), .pfm_exit_req(pfm_exit_req),
    .discharge_cfg(discharge_cfg), .sw_enable(sw_enable), .ramp_en(ramp_en), .force_pwm(force_pwm),
    .pfm_allow(pfm_allow), .discharge_en(discharge_en), .reg_reset(reg_reset));

  task automatic chk(input string rq, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    checks++; errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; supply_ok = 0; en_pin = 0; sw_en = 1; over_temp = 0; sw_cycle = 0;
    ilim_cycle = 0; zero_cross = 0; in_reg = 0; mode_sel = 2'b10; setpt_pfm = 0;
    pfm_exit_req = 0; discharge_cfg = 1;
    step(3);
    chk("R12 reset sw_enable", sw_enable, 0);
    chk("R12 reset ramp_en", ramp_en, 0);
    chk("R10 reset discharge", discharge_en, 1);
    chk("R11 reset reg_reset", reg_reset, 1);

    rst_n = 1; supply_ok = 1;
    step(5);
    chk("R1 pin low sw_enable", sw_enable, 0);
    chk("R11 pin low reg_reset", reg_reset, 1);
    en_pin = 1; sw_en = 0;
    step(5);
    chk("R1 sw bit low sw_enable", sw_enable, 0);
    chk("R1 sw bit low ramp_en", ramp_en, 0);
    chk("R11 sw bit no reg_reset", reg_reset, 0);

    sw_en = 1;
    for (int k = 1; k <= DLY; k++) begin
      step(1);
      chk("R2 delay ramp_en", ramp_en, 0);
    end
    step(1);
    chk("R2 ramp start", ramp_en, 1);
    chk("R3 ramp pfm_allow", pfm_allow, 1);
    chk("R3 ramp force_pwm", force_pwm, 0);
    chk("R10 running no discharge", discharge_en, 0);
    step(3);
    chk("R3 ramp holds without in_reg", ramp_en, 1);

    in_reg = 1; mode_sel = 2'b01; sw_cycle = 1; zero_cross = 1;
    for (int k = 1; k <= CAL; k++) begin
      step(1);
      chk("R4 cal force_pwm", force_pwm, 1);
      chk("R4 cal pfm_allow", pfm_allow, 0);
    end
    step(1);
    chk("R4 run after cal", force_pwm, 1);
    for (int k = 1; k < ZC; k++) begin
      step(1);
      chk("R5 below count pfm", pfm_allow, 0);
    end
    step(1);
    chk("R5 pfm entry", pfm_allow, 1);
    chk("R5 pfm entry force", force_pwm, 0);

    pfm_exit_req = 1;
    step(1);
    pfm_exit_req = 0; zero_cross = 0;
    chk("R7 exit pfm", pfm_allow, 0);
    chk("R7 exit force", force_pwm, 1);

    zero_cross = 1; step(ZC - 1);
    zero_cross = 0; step(1);
    zero_cross = 1; step(ZC - 1);
    chk("R5 broken run no pfm", pfm_allow, 0);
    step(1);
    chk("R5 restarted run pfm", pfm_allow, 1);
    mode_sel = 2'b10;
    step(1);
    chk("R6 permission lost exits", pfm_allow, 0);
    zero_cross = 0;

    for (int m = 0; m < 4; m++) begin
      for (int b = 0; b < 2; b++) begin
        int perm;
        perm = (m == 0) ? b : ((m == 2) ? 0 : 1);
        mode_sel = 2'(m); setpt_pfm = 1'(b); pfm_exit_req = 1;
        step(1);
        pfm_exit_req = 0; zero_cross = 1;
        step(ZC);
        chk($sformatf("R6 mode %0d bit %0d", m, b), pfm_allow, perm);
        zero_cross = 0;
      end
    end
    mode_sel = 2'b10; pfm_exit_req = 1; step(1); pfm_exit_req = 0;

    ilim_cycle = 1; step(IL);
    chk("R8 at limit no trip", sw_enable, 1);
    ilim_cycle = 0; step(1);
    ilim_cycle = 1; step(IL);
    chk("R8 broken run no trip", sw_enable, 1);
    step(1);
    chk("R8 trip sw_enable", sw_enable, 0);
    chk("R8 trip ramp_en", ramp_en, 0);
    chk("R10 retry no discharge", discharge_en, 0);
    ilim_cycle = 0; in_reg = 0;
    for (int k = 1; k < RET; k++) begin
      step(1);
      chk("R8 retry off", sw_enable, 0);
    end
    step(1);
    chk("R8 restart ramp", ramp_en, 1);

    over_temp = 1; step(1);
    chk("R9 hot off", sw_enable, 0);
    step(6);
    chk("R9 hot held", sw_enable, 0);
    over_temp = 0; step(1);
    chk("R9 cool restart ramp", ramp_en, 1);

    in_reg = 1; step(1 + CAL);
    chk("R4 run reached", force_pwm, 1);
    ilim_cycle = 1; step(IL);
    sw_cycle = 0; ilim_cycle = 0; sw_en = 0;
    step(1);
    chk("R1 sw drop off", sw_enable, 0);
    chk("R11 sw drop no reg_reset", reg_reset, 0);
    chk("R10 off discharge", discharge_en, 1);
    sw_en = 1; in_reg = 0;
    step(DLY + 1);
    chk("R2 re-ramp", ramp_en, 1);
    in_reg = 1; step(1 + CAL);
    sw_cycle = 1; ilim_cycle = 1; step(1);
    chk("R1 counters cleared", sw_enable, 1);
    ilim_cycle = 0;

    discharge_cfg = 0; en_pin = 0; step(1);
    chk("R1 pin drop off", sw_enable, 0);
    chk("R10 cfg off no discharge", discharge_en, 0);
    chk("R11 pin drop reg_reset", reg_reset, 1);
    discharge_cfg = 1; #1;
    chk("R10 cfg on discharge", discharge_en, 1);

    en_pin = 1; in_reg = 0; step(DLY + 1);
    chk("R2 ramp after pin", ramp_en, 1);
    supply_ok = 0; step(1);
    chk("R1 supply drop off", sw_enable, 0);
    chk("R11 supply drop reg_reset", reg_reset, 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule